// File: doc/BRIEF.md
# Tiled Texture Address Swizzler

This block turns a texel coordinate into the byte offset of that texel inside a tiled texture image. The image is built from 64-byte utiles, whose shape depends on the texel size. Four utiles, arranged 2x2, form a 256-byte macroblock. Macroblocks are grouped into columns four macroblocks wide. Each column is stored contiguously as rows of four macroblocks, and the columns follow one another in memory.

When the swizzle-XOR option is on, every odd column has one macroblock-row bit inverted. This moves neighbouring columns onto different DRAM banks.

A second output reports whether a mip level of the given padded height qualifies for the XOR layout. It qualifies when its count of macroblock rows is a multiple of the number of column rows that fit in one page-cache span.

Each request is presented with a valid strobe. The result appears on registered outputs one clock later.

Top module: `texel_swizzle_addr`

## Requirements
- R1: While reset is held and after its release, `out_valid` is 0 and `out_offset` and `out_xor_level` read 0 until the first accepted request.
- R2: Each cycle with `in_valid` high produces exactly one cycle of `out_valid` high on the next clock edge. A cycle with `in_valid` low gives `out_valid` low on the next edge.
- R3: When `in_valid` is low, `out_offset` and `out_xor_level` keep their previous values.
- R4: `in_cpp_code` c selects 2^c bytes per texel. The utile width x height is 8x8 for c=0, 8x4 for c=1, 4x4 for c=2, 4x2 for c=3 and 2x2 for c=4. A macroblock is twice the utile size in each direction.
- R5: Inside a utile, the texel sits at byte (row*utile_width + col)*bytes_per_texel. Every offset is therefore a multiple of the texel size.
- R6: The four utiles of a macroblock are stored in raster order (top-left, top-right, bottom-left, bottom-right), 64 bytes apart.
- R7: With mbx = x/mb_width, mby = y/mb_height and mbh = ceil(height/mb_height), the macroblock index is (mbx/4)*(mbh-1)*4 + mbx + mby*4. The offset is index*256 + utile_slot*64 + in-utile byte.
- R8: With `in_xor_en` high and (mbx/4) odd, bit 4 of mby (value 16) is inverted before the index is formed.
- R9: The XOR option has no effect on columns where (mbx/4) is even.
- R10: `out_xor_level` is 1 exactly when floor(height/mb_height) is a multiple of PAGE_CACHE_BYTES/1024, which is 32 by default.
- R11: Codes 5 to 7 on `in_cpp_code` behave as code 4 (16 bytes per texel).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request strobe |
| in_x | input | COORD_W | Texel column |
| in_y | input | COORD_W | Texel row |
| in_cpp_code | input | 3 | log2 of bytes per texel |
| in_height | input | COORD_W | Padded image height in texels |
| in_xor_en | input | 1 | Enable odd-column row-bit swizzle |
| out_valid | output | 1 | Result strobe |
| out_offset | output | ADDR_W | Byte offset of the texel |
| out_xor_level | output | 1 | Level height qualifies for XOR layout |

## Verification
Both the offset and the level flag pass through a single register stage. A request driven at a falling edge therefore shows up at the following falling edge, after exactly one rising edge.

The bench queues the expected result of each request at the moment it drives it. The monitor pops one entry only in a cycle where `out_valid` is high. A strobe with no queued entry counts as a latency failure, and so does an entry left in the queue at the end.

In idle cycles the monitor instead compares the outputs with the last result it saw, to check that they hold.

// File: rtl/swz_pkg.sv
package swz_pkg;
  localparam int UTILE_BYTES_LOG2 = 6;
  localparam int MB_BYTES_LOG2    = 8;
  localparam int COL_ROW_BYTES    = 1024;

  typedef struct packed {
    logic [2:0] lw;   // log2 utile width
    logic [2:0] lh;   // log2 utile height
  } utile_shape_t;
endpackage

// File: rtl/swz_utile_geom.sv
module swz_utile_geom
  import swz_pkg::*;
(
  input  logic [2:0]   cpp_code,
  output logic [2:0]   cpp_sh,
  output utile_shape_t shape
);
  always_comb begin
    cpp_sh = (cpp_code > 3'd4) ? 3'd4 : cpp_code;
    unique case (cpp_sh)
      3'd0:    shape = '{lw: 3'd3, lh: 3'd3};
      3'd1:    shape = '{lw: 3'd3, lh: 3'd2};
      3'd2:    shape = '{lw: 3'd2, lh: 3'd2};
      3'd3:    shape = '{lw: 3'd2, lh: 3'd1};
      default: shape = '{lw: 3'd1, lh: 3'd1};
    endcase
  end
endmodule

// File: rtl/swz_block_index.sv
module swz_block_index
  import swz_pkg::*;
#(
  parameter int COORD_W     = 16,
  parameter int ADDR_W      = 32,
  parameter int XOR_ROW_BIT = 4
) (
  input  logic [COORD_W-1:0] x,
  input  logic [COORD_W-1:0] y,
  input  logic [COORD_W-1:0] height,
  input  logic [2:0]         cpp_sh,
  input  utile_shape_t       shape,
  input  logic               xor_en,
  output logic [ADDR_W-1:0]  offset
);
  localparam logic [COORD_W-1:0] ONES = '1;

  logic [2:0]         lmw, lmh;
  logic [COORD_W-1:0] mb_x, mb_y, mb_y_sw, px, py, ucol, urow;
  logic               ux, uy;
  logic [ADDR_W-1:0]  mb_rows, col_idx, mb_id, slot, in_ut;

  always_comb begin
    lmw  = shape.lw + 3'd1;
    lmh  = shape.lh + 3'd1;
    mb_x = x >> lmw;
    mb_y = y >> lmh;
    px   = x & ~(ONES << lmw);
    py   = y & ~(ONES << lmh);
    ux   = px[shape.lw];
    uy   = py[shape.lh];
    ucol = px & ~(ONES << shape.lw);
    urow = py & ~(ONES << shape.lh);

    // odd four-wide column: invert one macroblock-row bit
    mb_y_sw = mb_y;
    if (xor_en && mb_x[2]) mb_y_sw[XOR_ROW_BIT] = ~mb_y[XOR_ROW_BIT];

    mb_rows = (ADDR_W'(height) + ((ADDR_W'(1) << lmh) - ADDR_W'(1))) >> lmh;
    col_idx = ADDR_W'(mb_x >> 2);
    mb_id   = col_idx * ((mb_rows - ADDR_W'(1)) << 2)
            + ADDR_W'(mb_x) + (ADDR_W'(mb_y_sw) << 2);
    slot    = ADDR_W'({uy, ux});
    in_ut   = ((ADDR_W'(urow) << shape.lw) + ADDR_W'(ucol)) << cpp_sh;
    offset  = (mb_id << MB_BYTES_LOG2) + (slot << UTILE_BYTES_LOG2) + in_ut;
  end
endmodule

// File: rtl/swz_xor_level.sv
module swz_xor_level
  import swz_pkg::*;
#(
  parameter int COORD_W     = 16,
  parameter int PERIOD_LOG2 = 5
) (
  input  logic [COORD_W-1:0] height,
  input  utile_shape_t       shape,
  output logic               xor_ok
);
  logic [COORD_W-1:0] rows;
  assign rows = height >> (shape.lh + 3'd1);

  generate
    if (PERIOD_LOG2 == 0) begin : g_always
      assign xor_ok = 1'b1;
    end else begin : g_mod
      assign xor_ok = (rows[PERIOD_LOG2-1:0] == '0);
    end
  endgenerate
endmodule

// File: rtl/texel_swizzle_addr.sv
module texel_swizzle_addr
  import swz_pkg::*;
#(
  parameter int COORD_W          = 16,
  parameter int ADDR_W           = 32,
  parameter int PAGE_CACHE_BYTES = 32768,
  parameter int XOR_ROW_BIT      = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic [COORD_W-1:0] in_x,
  input  logic [COORD_W-1:0] in_y,
  input  logic [2:0]         in_cpp_code,
  input  logic [COORD_W-1:0] in_height,
  input  logic               in_xor_en,
  output logic               out_valid,
  output logic [ADDR_W-1:0]  out_offset,
  output logic               out_xor_level
);
  localparam int PERIOD_LOG2 = $clog2(PAGE_CACHE_BYTES / COL_ROW_BYTES);

  logic [2:0]        cpp_sh;
  utile_shape_t      shape;
  logic [ADDR_W-1:0] off_nxt;
  logic              lvl_nxt;

  swz_utile_geom u_geom (
    .cpp_code (in_cpp_code),
    .cpp_sh   (cpp_sh),
    .shape    (shape)
  );

  swz_block_index #(
    .COORD_W(COORD_W), .ADDR_W(ADDR_W), .XOR_ROW_BIT(XOR_ROW_BIT)
  ) u_idx (
    .x(in_x), .y(in_y), .height(in_height), .cpp_sh(cpp_sh),
    .shape(shape), .xor_en(in_xor_en), .offset(off_nxt)
  );

  swz_xor_level #(.COORD_W(COORD_W), .PERIOD_LOG2(PERIOD_LOG2)) u_lvl (
    .height (in_height),
    .shape  (shape),
    .xor_ok (lvl_nxt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_valid <= 1'b0;
    else        out_valid <= in_valid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_offset    <= '0;
      out_xor_level <= 1'b0;
    end else if (in_valid) begin
      out_offset    <= off_nxt;
      out_xor_level <= lvl_nxt;
    end
  end
endmodule

// File: rtl/swz_checker.sv
module swz_checker #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [2:0]        in_cpp_code,
  input logic              out_valid,
  input logic [ADDR_W-1:0] out_offset,
  input logic              out_xor_level
);
  logic [2:0] c_eff;
  assign c_eff = (in_cpp_code > 3'd4) ? 3'd4 : in_cpp_code;

  p_reset_quiet_r1: assert property (@(posedge clk) !rst_n |-> !out_valid);

  p_strobe_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  p_strobe_drops_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  p_hold_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(out_offset) && $stable(out_xor_level)));

  p_texel_align_r5: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> ((out_offset & ((ADDR_W'(1) << $past(c_eff)) - ADDR_W'(1))) == '0));
endmodule

bind texel_swizzle_addr swz_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_cpp_code(in_cpp_code),
  .out_valid(out_valid), .out_offset(out_offset), .out_xor_level(out_xor_level)
);

// File: tb/sim_texel_swizzle_addr.sv
module sim_texel_swizzle_addr;
  typedef struct {
    logic [31:0] off;
    logic        lvl;
    string       tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [15:0] in_x = '0, in_y = '0, in_height = '0;
  logic [2:0]  in_cpp_code = '0;
  logic        in_xor_en = 1'b0;
  logic        out_valid;
  logic [31:0] out_offset;
  logic        out_xor_level;

  int   n_checks = 0, n_errs = 0;
  exp_t q[$];
  logic [31:0] last_off = '0;
  logic        last_lvl = 1'b0;
  bit          done = 0;

  always #4 clk = ~clk;   // 125 MHz

  texel_swizzle_addr u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_x(in_x), .in_y(in_y),
    .in_cpp_code(in_cpp_code), .in_height(in_height), .in_xor_en(in_xor_en),
    .out_valid(out_valid), .out_offset(out_offset), .out_xor_level(out_xor_level)
  );

  function automatic void model(input int x, input int y, input int code,
                                input int h, input bit xe,
                                output logic [31:0] off, output logic lvl);
    int c, cpp, uw, uh, mbw, mbh, mbx, mby, px, py, rows, id, slot;
    longint t;
    c   = (code > 4) ? 4 : code;
    cpp = 1 << c;
    case (c)
      0: begin uw = 8; uh = 8; end
      1: begin uw = 8; uh = 4; end
      2: begin uw = 4; uh = 4; end
      3: begin uw = 4; uh = 2; end
      default: begin uw = 2; uh = 2; end
    endcase
    mbw = 2 * uw; mbh = 2 * uh;
    mbx = x / mbw; mby = y / mbh;
    px = x % mbw; py = y % mbh;
    if (xe && ((mbx / 4) % 2 == 1)) mby = mby ^ 16;
    rows = (h + mbh - 1) / mbh;
    id   = (mbx / 4) * ((rows - 1) * 4) + mbx + mby * 4;
    slot = (py / uh) * 2 + (px / uw);
    t    = longint'(id) * 256 + slot * 64 + ((py % uh) * uw + (px % uw)) * cpp;
    off  = t[31:0];
    lvl  = (((h / mbh) % 32) == 0);
  endfunction

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_errs++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // drive one request; expected computed with model_xe
  task automatic send(input int x, input int y, input int code, input int h,
                      input bit xe, input bit model_xe, input string tag);
    exp_t e;
    @(negedge clk);
    in_valid = 1'b1; in_x = 16'(x); in_y = 16'(y);
    in_cpp_code = 3'(code); in_height = 16'(h); in_xor_en = xe;
    model(x, y, code, h, model_xe, e.off, e.lvl);
    e.tag = tag;
    q.push_back(e);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      in_x = 16'hABCD; in_y = 16'h1234; in_xor_en = 1'b1;
    end
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (out_valid) begin
        if (q.size() == 0) begin
          chk(0, "R2 unexpected strobe", 1, 0);
        end else begin
          exp_t e;
          e = q.pop_front();
          chk(out_offset == e.off, {e.tag, " offset"}, out_offset, e.off);
          chk(out_xor_level == e.lvl, {e.tag, " level flag (R10)"}, out_xor_level, e.lvl);
        end
        last_off = out_offset;
        last_lvl = out_xor_level;
      end else begin
        chk(out_offset == last_off, "R3 hold offset", out_offset, last_off);
        chk(out_xor_level == last_lvl, "R3 hold level", out_xor_level, last_lvl);
      end
    end
  end

  initial begin
    #(8 * 200000);
    chk(0, "watchdog", 0, 1);
    $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R1 valid in reset", out_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid == 1'b0, "R1 valid after reset", out_valid, 0);
    chk(out_offset == 32'd0, "R1 offset after reset", out_offset, 0);
    chk(out_xor_level == 1'b0, "R1 level after reset", out_xor_level, 0);

    // R4 / R5 / R6 directed
    send(0, 0, 2, 16, 0, 0, "R5 origin");
    send(5, 3, 2, 16, 0, 0, "R5 in-utile 4B");
    send(7, 7, 0, 64, 0, 0, "R4 8x8 utile");
    send(8, 0, 0, 64, 0, 0, "R6 right utile");
    send(0, 4, 1, 64, 0, 0, "R4 8x4 utile");
    send(3, 1, 3, 64, 0, 0, "R4 4x2 utile");
    send(3, 3, 4, 64, 0, 0, "R6 bottom-right 2x2");
    idle(2);
    // R7 column layout and height rounding
    send(32, 0, 2, 17, 0, 0, "R7 next column, rounded rows");
    send(40, 9, 2, 100, 0, 0, "R7 column interior");
    send(100, 77, 1, 300, 0, 0, "R7 far column");
    // R8 swizzle on odd column
    send(32, 0, 2, 512, 1, 1, "R8 odd column row0");
    send(40, 130, 2, 512, 1, 1, "R8 odd column row16");
    // R9: even column, XOR on, expect plain layout
    send(8, 130, 2, 512, 1, 0, "R9 even column unchanged");
    send(64, 200, 2, 512, 1, 0, "R9 column 2 unchanged");
    // R10 level flag
    send(0, 0, 2, 256, 0, 0, "R10 32 rows");
    send(0, 0, 2, 264, 0, 0, "R10 33 rows");
    send(0, 0, 4, 128, 0, 0, "R10 32 rows 16B");
    // R11 out-of-range code
    send(3, 3, 6, 64, 1, 1, "R11 code 6 as 16B");
    send(50, 21, 7, 512, 1, 1, "R11 code 7 as 16B");
    idle(3);
    // R7/R8 sweep
    for (int i = 0; i < 200; i++) begin
      send(int'($urandom_range(0, 2047)), int'($urandom_range(0, 1023)),
           int'($urandom_range(0, 4)), int'($urandom_range(1024, 4096)),
           1'($urandom_range(0, 1)), 1'b0, "");
      q[q.size()-1].tag = "R7 sweep";
      // re-evaluate with the driven XOR bit
      model(int'(in_x), int'(in_y), int'(in_cpp_code), int'(in_height), in_xor_en,
            q[q.size()-1].off, q[q.size()-1].lvl);
      if (in_xor_en) q[q.size()-1].tag = "R8 sweep";
      if (i % 17 == 0) idle(1);
    end
    idle(4);
    chk(q.size() == 0, "R2 results outstanding", q.size(), 0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
    $finish;
  end
endmodule